// File: doc/BRIEF.md
# Speculative Load Queue with Snoop-Driven Replay

This block tracks in-flight loads of an out-of-order core so that the core can let loads run early and still present a sequentially consistent memory order to other agents. Loads take a slot at the tail in program order. When a load executes, its address is written into its slot. The block leaves retirement to the core, which asks for the oldest slot one at a time.

Every snooped coherence command that takes a line away from this core, a remote write or an upgrade, is compared with the line addresses of all slots that have already executed and are not yet retired. A slot that matches is flagged. When the core asks to commit the oldest slot, a clean slot retires at once. A flagged slot asks for a pipeline flush instead. The flush drops that load and every younger load, and the queue restarts empty at the same head position. The re-execution path, the store queue and the cache sit outside this block.

Top module: `spec_load_queue`

## Requirements
- R1: After reset the queue is empty (`empty_o`=1, `count_o`=0, `full_o`=0), `alloc_idx_o` and `head_idx_o` are 0, and `retire_o` and `flush_o` are low.
- R2: `alloc_i` while not full and without a same-cycle flush fills the slot numbered `alloc_idx_o`. That index then advances by one and wraps from DEPTH-1 to 0. `count_o` rises by one unless a slot retires in the same cycle.
- R3: `full_o` is high exactly when `count_o` equals DEPTH. An `alloc_i` while full is ignored, even if a slot retires in that same cycle.
- R4: `exec_i` with `exec_idx_i` naming an occupied slot records the line of `exec_addr_i` in that slot and marks it executed. `head_ready_o` is high when the oldest slot is occupied and executed. An `exec_i` to an empty slot is ignored.
- R5: A snoop with `snoop_cmd_i` = 2'b01 (remote write) or 2'b10 (upgrade) flags every occupied, executed slot whose line equals the snoop line. Codes 2'b00 (remote read) and 2'b11 flag nothing.
- R6: Slots that have not executed are never flagged. This includes a slot whose `exec_i` falls in the same cycle as the snoop.
- R7: Lines are compared on address bits [ADDR_W-1:LINE_OFF]. The low LINE_OFF offset bits are ignored.
- R8: `commit_i` when `head_ready_o` is high and the head slot is clean raises `retire_o` in that same cycle. The head then advances and the slot is freed. `commit_i` while `head_ready_o` is low does nothing.
- R9: `commit_i` when `head_ready_o` is high and the head slot is flagged raises `flush_o` in that same cycle, with `retire_o` low. On the next cycle the queue is empty, `head_idx_o` is unchanged and `alloc_idx_o` equals it.
- R10: A snoop that matches the head slot in the same cycle as its commit also causes the flush of R9.
- R11: An `alloc_i` in the same cycle as a flush is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_i | input | 1 | Request a slot for a new load |
| full_o | output | 1 | No free slot |
| empty_o | output | 1 | No occupied slot |
| count_o | output | $clog2(DEPTH+1) | Occupied slots |
| alloc_idx_o | output | $clog2(DEPTH) | Slot the next allocation takes |
| exec_i | input | 1 | A load has computed its address |
| exec_idx_i | input | $clog2(DEPTH) | Slot of the executing load |
| exec_addr_i | input | ADDR_W | Load address |
| snoop_i | input | 1 | Snooped command valid |
| snoop_cmd_i | input | 2 | 00 read, 01 write, 10 upgrade, 11 other |
| snoop_addr_i | input | ADDR_W | Snooped address |
| commit_i | input | 1 | Core asks to commit the head slot |
| head_idx_o | output | $clog2(DEPTH) | Oldest slot |
| head_ready_o | output | 1 | Oldest slot is occupied and executed |
| retire_o | output | 1 | Head slot retires cleanly this cycle |
| flush_o | output | 1 | Head slot is flagged; squash it and all younger loads |

## Verification
The random stimulus draws load and snoop addresses from a pool of four lines with random offsets. Matches are therefore common, and offset-only differences show whether the compare is done per line. Snoop codes are drawn from all four values, which separates the two invalidating commands from the two that must be ignored. Commits arrive both before and after execution, which separates a clean retire, a replay flush and a commit that must do nothing. Directed sequences cover filling past full, a snoop on a slot that has not executed, a snoop in the same cycle as the execute, a snoop in the same cycle as the head commit, and an allocation in the same cycle as a flush.

// File: rtl/slq_pkg.sv
package slq_pkg;
  typedef enum logic [1:0] {
    SNP_READ    = 2'b00,
    SNP_WRITE   = 2'b01,
    SNP_UPGRADE = 2'b10,
    SNP_OTHER   = 2'b11
  } snoop_cmd_e;

  function automatic logic snoop_kills(snoop_cmd_e c);
    return (c == SNP_WRITE) || (c == SNP_UPGRADE);
  endfunction
endpackage

// File: rtl/slq_ptrs.sv
module slq_ptrs #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             flush_i,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] tail_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [IDX_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [IDX_W-1:0] bump(logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      tail_q <= head_q;
      cnt_q  <= '0;
    end else begin
      if (push_i) tail_q <= bump(tail_q);
      if (pop_i)  head_q <= bump(head_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign count_o = cnt_q;
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);

  // R3
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  // R3
  no_push_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !push_i);
  // R9
  flush_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (cnt_q == '0) && (tail_q == head_q) && (head_q == $past(head_q)));
endmodule

// File: rtl/slq_entry.sv
module slq_entry #(
  parameter int LINE_W = 26
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic              exec_i,
  input  logic [LINE_W-1:0] exec_line_i,
  input  logic              snoop_kill_i,
  input  logic [LINE_W-1:0] snoop_line_i,
  input  logic              retire_i,
  input  logic              flush_i,
  output logic              valid_o,
  output logic              done_o,
  output logic              mark_o,
  output logic              hit_o
);
  logic              valid_q, done_q, mark_q;
  logic [LINE_W-1:0] line_q;

  // compare uses registered state only: a same-cycle execute is not yet visible
  assign hit_o = valid_q && done_q && snoop_kill_i && (line_q == snoop_line_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      mark_q  <= 1'b0;
      line_q  <= '0;
    end else if (flush_i) begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      mark_q  <= 1'b0;
    end else if (alloc_i) begin
      valid_q <= 1'b1;
      done_q  <= 1'b0;
      mark_q  <= 1'b0;
    end else if (retire_i) begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      mark_q  <= 1'b0;
    end else begin
      if (hit_o) mark_q <= 1'b1;
      if (exec_i && valid_q) begin
        done_q <= 1'b1;
        line_q <= exec_line_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign done_o  = done_q;
  assign mark_o  = mark_q;

  // R6
  mark_needs_exec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mark_q |-> (done_q && valid_q));
  // R4
  exec_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> valid_q);
  // R5
  mark_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mark_q && !flush_i && !retire_i && !alloc_i) |=> mark_q);
endmodule

// File: rtl/spec_load_queue.sv
module spec_load_queue #(
  parameter int DEPTH    = 8,
  parameter int ADDR_W   = 32,
  parameter int LINE_OFF = 6,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int LINE_W = ADDR_W - LINE_OFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  output logic              full_o,
  output logic              empty_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [IDX_W-1:0]  alloc_idx_o,
  input  logic              exec_i,
  input  logic [IDX_W-1:0]  exec_idx_i,
  input  logic [ADDR_W-1:0] exec_addr_i,
  input  logic              snoop_i,
  input  logic [1:0]        snoop_cmd_i,
  input  logic [ADDR_W-1:0] snoop_addr_i,
  input  logic              commit_i,
  output logic [IDX_W-1:0]  head_idx_o,
  output logic              head_ready_o,
  output logic              retire_o,
  output logic              flush_o
);
  import slq_pkg::*;

  logic [IDX_W-1:0] head, tail;
  logic             full;
  logic             do_alloc, do_retire, do_flush, snoop_kill, head_go;
  logic [DEPTH-1:0] ent_valid, ent_done, ent_mark, ent_hit;

  assign snoop_kill = snoop_i && snoop_kills(snoop_kill_cast(snoop_cmd_i));

  function automatic snoop_cmd_e snoop_kill_cast(logic [1:0] c);
    return snoop_cmd_e'(c);
  endfunction

  assign head_ready_o = ent_valid[head] && ent_done[head];
  assign head_go      = commit_i && head_ready_o;
  assign do_flush     = head_go && (ent_mark[head] || ent_hit[head]);
  assign do_retire    = head_go && !do_flush;
  assign do_alloc     = alloc_i && !full && !do_flush;

  slq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (do_alloc),
    .pop_i   (do_retire),
    .flush_i (do_flush),
    .head_o  (head),
    .tail_o  (tail),
    .count_o (count_o),
    .full_o  (full),
    .empty_o (empty_o)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    slq_entry #(.LINE_W(LINE_W)) u_ent (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .alloc_i      (do_alloc && (tail == IDX_W'(i))),
      .exec_i       (exec_i && (exec_idx_i == IDX_W'(i))),
      .exec_line_i  (exec_addr_i[ADDR_W-1:LINE_OFF]),
      .snoop_kill_i (snoop_kill),
      .snoop_line_i (snoop_addr_i[ADDR_W-1:LINE_OFF]),
      .retire_i     (do_retire && (head == IDX_W'(i))),
      .flush_i      (do_flush),
      .valid_o      (ent_valid[i]),
      .done_o       (ent_done[i]),
      .mark_o       (ent_mark[i]),
      .hit_o        (ent_hit[i])
    );
  end

  assign full_o      = full;
  assign alloc_idx_o = tail;
  assign head_idx_o  = head;
  assign retire_o    = do_retire;
  assign flush_o     = do_flush;

  // R8
  one_outcome_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({retire_o, flush_o}));
  // R8
  retire_frees_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_o |=> (head_idx_o != $past(head_idx_o)));
  // R2
  occupancy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ent_valid) == int'(count_o));
  // R11
  no_alloc_on_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> empty_o);
endmodule

// File: tb/tb_spec_load_queue.sv
module tb_spec_load_queue;
  localparam int DEPTH    = 8;
  localparam int ADDR_W   = 32;
  localparam int LINE_OFF = 6;
  localparam int IDX_W    = $clog2(DEPTH);
  localparam int CNT_W    = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              alloc, exec, snoop, commit;
  logic [IDX_W-1:0]  exec_idx;
  logic [ADDR_W-1:0] exec_addr, snoop_addr;
  logic [1:0]        snoop_cmd;
  logic              full, empty, head_ready, retire, flush;
  logic [CNT_W-1:0]  count;
  logic [IDX_W-1:0]  alloc_idx, head_idx;

  always #2.5 clk = ~clk;

  spec_load_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LINE_OFF(LINE_OFF)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .alloc_i(alloc), .full_o(full), .empty_o(empty), .count_o(count), .alloc_idx_o(alloc_idx),
    .exec_i(exec), .exec_idx_i(exec_idx), .exec_addr_i(exec_addr),
    .snoop_i(snoop), .snoop_cmd_i(snoop_cmd), .snoop_addr_i(snoop_addr),
    .commit_i(commit), .head_idx_o(head_idx), .head_ready_o(head_ready),
    .retire_o(retire), .flush_o(flush)
  );

  int n_chk = 0, n_bad = 0;
  string ctx = "R1";

  // reference model
  bit m_v [DEPTH];
  bit m_e [DEPTH];
  bit m_r [DEPTH];
  int unsigned m_line [DEPTH];
  int m_head = 0, m_tail = 0, m_cnt = 0;

  function automatic int unsigned line_of(logic [ADDR_W-1:0] a);
    return int'(a >> LINE_OFF);
  endfunction

  function automatic bit kills(logic [1:0] c);
    return (c == 2'b01) || (c == 2'b10);
  endfunction

  function automatic bit exp_hit(int i);
    return snoop && kills(snoop_cmd) && m_v[i] && m_e[i] && (m_line[i] == line_of(snoop_addr));
  endfunction

  function automatic bit exp_ready();
    return m_v[m_head] && m_e[m_head];
  endfunction

  function automatic bit exp_flush();
    return commit && exp_ready() && (m_r[m_head] || exp_hit(m_head));
  endfunction

  function automatic bit exp_retire();
    return commit && exp_ready() && !exp_flush();
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", ctx, tag, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    chk("R1 empty", int'(empty), int'(m_cnt == 0));
    chk("R2 count", int'(count), m_cnt);
    chk("R3 full", int'(full), int'(m_cnt == DEPTH));
    chk("R2 alloc_idx", int'(alloc_idx), m_tail);
    chk("R8 head_idx", int'(head_idx), m_head);
    chk("R4 head_ready", int'(head_ready), int'(exp_ready()));
    chk("R8 retire", int'(retire), int'(exp_retire()));
    chk("R9 flush", int'(flush), int'(exp_flush()));
  endtask

  task automatic model_update();
    bit f, r, a;
    bit hits [DEPTH];
    f = exp_flush();
    r = exp_retire();
    a = alloc && (m_cnt != DEPTH) && !f;
    for (int i = 0; i < DEPTH; i++) hits[i] = exp_hit(i);
    if (f) begin
      for (int i = 0; i < DEPTH; i++) begin m_v[i] = 0; m_e[i] = 0; m_r[i] = 0; end
      m_tail = m_head;
      m_cnt = 0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (hits[i]) m_r[i] = 1;
        if (exec && int'(exec_idx) == i && m_v[i]) begin
          m_e[i] = 1;
          m_line[i] = line_of(exec_addr);
        end
      end
      if (r) begin
        m_v[m_head] = 0; m_e[m_head] = 0; m_r[m_head] = 0;
        m_head = (m_head + 1) % DEPTH;
        m_cnt--;
      end
      if (a) begin
        m_v[m_tail] = 1; m_e[m_tail] = 0; m_r[m_tail] = 0;
        m_tail = (m_tail + 1) % DEPTH;
        m_cnt++;
      end
    end
  endtask

  task automatic idle();
    alloc = 0; exec = 0; snoop = 0; commit = 0;
    exec_idx = '0; exec_addr = '0; snoop_cmd = 2'b00; snoop_addr = '0;
  endtask

  task automatic cycle();
    #1;
    check_outputs();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  function automatic logic [ADDR_W-1:0] mk_addr(int ln);
    return ADDR_W'((32'h1000 + ln) << LINE_OFF) | ADDR_W'($urandom_range(0, (1 << LINE_OFF) - 1));
  endfunction

  task automatic do_alloc();   idle(); alloc = 1; cycle(); endtask
  task automatic do_exec(int idx, int ln);
    idle(); exec = 1; exec_idx = IDX_W'(idx); exec_addr = mk_addr(ln); cycle();
  endtask
  task automatic do_snoop(logic [1:0] c, int ln);
    idle(); snoop = 1; snoop_cmd = c; snoop_addr = mk_addr(ln); cycle();
  endtask
  task automatic do_commit(); idle(); commit = 1; cycle(); endtask

  initial begin
    void'($urandom(32'd1234));
    idle();
    repeat (3) @(negedge clk);
    ctx = "R1";
    #1; check_outputs();
    chk("R1 retire_low", int'(retire), 0);
    chk("R1 flush_low", int'(flush), 0);
    rst_n = 1;
    @(negedge clk);

    // fill past full, then drain clean
    ctx = "R3";
    for (int k = 0; k < DEPTH + 2; k++) do_alloc();
    idle(); alloc = 1; commit = 1; cycle();  // head not executed: nothing
    for (int k = 0; k < DEPTH; k++) do_exec((m_head + k) % DEPTH, k);
    idle(); alloc = 1; commit = 1; cycle();  // retire while full: alloc ignored
    ctx = "R8";
    for (int k = 0; k < DEPTH; k++) do_commit();

    // ignored snoop codes; write with other offset flags (R7)
    ctx = "R5";
    do_alloc(); do_exec(m_head, 1);
    do_snoop(2'b00, 1); do_snoop(2'b11, 1); do_commit();
    ctx = "R7";
    do_alloc(); do_exec(m_head, 2); do_snoop(2'b01, 2); do_commit();

    // snoop before and during execute
    ctx = "R6";
    do_alloc(); do_snoop(2'b10, 3);
    idle(); exec = 1; exec_idx = IDX_W'(m_head); exec_addr = mk_addr(3);
    snoop = 1; snoop_cmd = 2'b01; snoop_addr = mk_addr(3); cycle();
    do_commit();

    // snoop in commit cycle
    ctx = "R10";
    do_alloc(); do_exec(m_head, 4);
    idle(); commit = 1; snoop = 1; snoop_cmd = 2'b10; snoop_addr = mk_addr(4); cycle();

    // alloc in flush cycle with younger loads present
    ctx = "R11";
    do_alloc(); do_alloc(); do_exec(m_head, 5); do_exec((m_head + 1) % DEPTH, 6);
    do_snoop(2'b01, 5);
    idle(); commit = 1; alloc = 1; cycle();
    do_alloc();

    // random mix
    ctx = "RND";
    for (int k = 0; k < 3000; k++) begin
      idle();
      alloc = ($urandom_range(0, 99) < 50);
      if ($urandom_range(0, 99) < 60) begin
        exec = 1; exec_idx = IDX_W'($urandom_range(0, DEPTH - 1));
        exec_addr = mk_addr($urandom_range(0, 3));
      end
      if ($urandom_range(0, 99) < 25) begin
        snoop = 1; snoop_cmd = 2'($urandom_range(0, 3));
        snoop_addr = mk_addr($urandom_range(0, 3));
      end
      commit = ($urandom_range(0, 99) < 40);
      cycle();
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5ns * 200000);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule